// File: doc/BRIEF.md
# Interleaved Complex Multiplier

This block multiplies two streams of complex numbers in which the real and imaginary parts of each number share one port and arrive on consecutive clock cycles. Operand x carries a+ib and operand y carries c+id; a phase input is high on the cycle that carries the real samples (a and c), and the following cycle carries the imaginary samples (b and d). The product (ac−bd) + i(ad+bc) leaves on the same interleaved format, with the real part in the output slot that matches the real input sample. At most one complex product can be formed every two clock cycles, and two signed multipliers are shared between the two phases.

All values are signed fixed point in [-1, 1): a DW-bit code k stands for k/2^(DW-1). Two outputs are produced. The narrow output is the product rounded to DW bits and clipped to the largest positive or most negative code when it does not fit. The wide output holds the exact 2*DW-bit sum of the products in the product scale (code k stands for k/2^(2*DW-2)). A valid flag travels beside the data with the same four-cycle latency and never steers the arithmetic.

Top module: `cplx_iq_mult`

## Requirements
- R1: A sample with phase_re_i = 1 is the real part of a number and the sample on the next cycle (phase_re_i = 0) is its imaginary part; the output slot aligned to the real input sample carries the real part of the product and the next slot carries the imaginary part.
- R2: The wide output in the real slot equals a*c − b*d, with a, b, c, d taken as signed DW-bit integers.
- R3: The wide output in the imaginary slot equals a*d + b*c.
- R4: Each output slot appears exactly four clock cycles after the input sample it belongs to; back-to-back complex numbers are accepted with no gap.
- R5: When in range, the narrow output equals floor((S + 2^(DW-2)) / 2^(DW-1)) where S is the exact sum of R2 or R3 (round half up).
- R6: When the rounded value of R5 is above 2^(DW-1)−1 the narrow output is 2^(DW-1)−1, and when it is below −2^(DW-1) the narrow output is −2^(DW-1).
- R7: The only exact sum that does not fit in the wide output is +2^(2*DW-2)·2 (for example a = b = c = −1, d = maximum negative giving +2); such a sum gives 2^(2*DW-1)−1 on the wide output.
- R8: vld_o equals vld_i delayed by exactly four cycles, and the value of vld_i has no effect on either data output.
- R9: While rst_n is sampled low, the next clock edge clears vld_o, z_o and zfull_o to zero, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vld_i | input | 1 | Input valid flag, delayed to vld_o |
| phase_re_i | input | 1 | High on the cycle carrying the real samples |
| x_i | input | DW | First operand, signed, real and imaginary interleaved |
| y_i | input | DW | Second operand, signed, real and imaginary interleaved |
| z_o | output | DW | Rounded and saturated product, interleaved |
| zfull_o | output | 2*DW | Exact product sum, interleaved |
| vld_o | output | 1 | vld_i delayed by four cycles |

## Verification
With DW = 4 the bench streams every combination of the four signed components a, b, c, d back to back, so both the subtracting real phase and the adding imaginary phase meet every sign mix, including the most negative code on all four inputs that produces the single unrepresentable +2 sum. Comparing the wide output against exact integer arithmetic separates errors in operand pairing between phases from errors in rounding, while the narrow output check covers both exact half-way sums and the saturation boundaries on each side. The valid flag is driven with an irregular pattern unrelated to the data, so a design that let it gate the datapath or that delayed it by the wrong count disagrees with the computed results.

// File: rtl/cim_pkg.sv
// Shared constants and types for the interleaved complex multiplier.
package cim_pkg;

    // Phase of a sample on the interleaved ports.
    typedef enum logic {
        PH_IMAG = 1'b0,
        PH_REAL = 1'b1
    } phase_e;

    // Registers between an input sample and its output slot.
    localparam int CIM_LATENCY = 4;

    // Operand history depth needed to hold both parts of a number.
    localparam int CIM_TAPS = 3;

endpackage

// File: rtl/cim_tap_line.sv
// Operand history line: a chain of TAPS registers, tap 0 being the newest.
// Assumes a synchronous active-low reset that clears every tap.
module cim_tap_line #(
    parameter int DW   = 18,
    parameter int TAPS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DW-1:0]            d_i,
    output logic [TAPS-1:0][DW-1:0]  tap_o
);

    genvar g;
    generate
        for (g = 0; g < TAPS; g++) begin : g_tap
            // Shift the operand one tap further back per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tap_o[g] <= '0;
                end else if (g == 0) begin
                    tap_o[g] <= d_i;
                end else begin
                    tap_o[g] <= tap_o[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cim_flag_delay.sv
// Fixed delay line for a single flag, LAT registers long.
// Assumes LAT >= 1; reset clears every stage.
module cim_flag_delay #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    output logic flag_o
);

    logic [LAT-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < LAT; g++) begin : g_stage
            // Move the flag one stage closer to the output.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[g] <= 1'b0;
                end else if (g == 0) begin
                    stage_q[g] <= flag_i;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign flag_o = stage_q[LAT-1];

endmodule

// File: rtl/cim_pair_mult.sv
// Two shared signed multipliers with phase-steered operand selection.
// When the newest registered sample is imaginary (b, d), the pair of
// real-phase products a*c and b*d is formed; when it is a new real sample,
// the older taps still hold a, b, c, d and a*d and b*c are formed.
// Assumes the phase input is aligned with tap 0 of both tap lines.
module cim_pair_mult
    import cim_pkg::*;
#(
    parameter int DW   = 18,
    parameter int TAPS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  phase_e                   phase_i,
    input  logic [TAPS-1:0][DW-1:0]  xt_i,
    input  logic [TAPS-1:0][DW-1:0]  yt_i,
    output logic [2*DW-1:0]          prod0_o,
    output logic [2*DW-1:0]          prod1_o,
    output logic                     real_o
);

    localparam int PW = 2 * DW;

    logic              sel_real;
    logic [DW-1:0]     opx0, opy0, opx1, opy1;
    logic signed [PW-1:0] ex0, ey0, ex1, ey1;
    logic signed [PW-1:0] m0_c, m1_c;

    // Pick the operand pairs for the phase being computed.
    always_comb begin
        sel_real = (phase_i == PH_IMAG);
        if (sel_real) begin
            opx0 = xt_i[1];
            opy0 = yt_i[1];
            opx1 = xt_i[0];
            opy1 = yt_i[0];
        end else begin
            opx0 = xt_i[2];
            opy0 = yt_i[1];
            opx1 = xt_i[1];
            opy1 = yt_i[2];
        end
    end

    // Sign-extend the operands and form both full-width products.
    always_comb begin
        ex0  = {{DW{opx0[DW-1]}}, opx0};
        ey0  = {{DW{opy0[DW-1]}}, opy0};
        ex1  = {{DW{opx1[DW-1]}}, opx1};
        ey1  = {{DW{opy1[DW-1]}}, opy1};
        m0_c = ex0 * ey0;
        m1_c = ex1 * ey1;
    end

    // Register the products together with the phase they belong to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod0_o <= '0;
            prod1_o <= '0;
            real_o  <= 1'b0;
        end else begin
            prod0_o <= m0_c;
            prod1_o <= m1_c;
            real_o  <= sel_real;
        end
    end

endmodule

// File: rtl/cim_combine.sv
// Combines the two products (difference in the real phase, sum in the
// imaginary phase), clips the exact sum to 2*DW bits and rounds it half up
// to DW bits with saturation. Assumes DW >= 2; outputs are registered.
module cim_combine #(
    parameter int DW = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*DW-1:0]   prod0_i,
    input  logic [2*DW-1:0]   prod1_i,
    input  logic              real_i,
    output logic [DW-1:0]     z_o,
    output logic [2*DW-1:0]   zfull_o
);

    localparam int PW = 2 * DW;
    localparam int SW = PW + 1;
    localparam int RW = PW + 2;
    localparam int UW = RW - (PW - 2);
    localparam logic [RW-1:0] HALF = {{(RW-1){1'b0}}, 1'b1} << (DW - 2);
    localparam logic [DW-1:0] Z_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] Z_MIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [PW-1:0] F_MAX = {1'b0, {(PW-1){1'b1}}};
    localparam logic [PW-1:0] F_MIN = {1'b1, {(PW-1){1'b0}}};

    logic [SW-1:0] p0_x, p1_x, sum_c;
    logic [PW-1:0] full_c;
    logic [RW-1:0] rnd_c;
    logic [UW-1:0] upper_c;
    logic [DW-1:0] narrow_c;

    // Form the exact sum or difference one bit wider than the products.
    always_comb begin
        p0_x  = {prod0_i[PW-1], prod0_i};
        p1_x  = {prod1_i[PW-1], prod1_i};
        sum_c = real_i ? (p0_x - p1_x) : (p0_x + p1_x);
    end

    // Clip the exact sum into the wide output field.
    always_comb begin
        if (sum_c[SW-1] != sum_c[SW-2]) begin
            full_c = sum_c[SW-1] ? F_MIN : F_MAX;
        end else begin
            full_c = sum_c[PW-1:0];
        end
    end

    // Round half up to the narrow scale and saturate on overflow.
    always_comb begin
        rnd_c   = {sum_c[SW-1], sum_c} + HALF;
        upper_c = rnd_c[RW-1:PW-2];
        if ((&upper_c) || !(|upper_c)) begin
            narrow_c = rnd_c[PW-2:DW-1];
        end else begin
            narrow_c = rnd_c[RW-1] ? Z_MIN : Z_MAX;
        end
    end

    // Register both result forms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_o     <= '0;
            zfull_o <= '0;
        end else begin
            z_o     <= narrow_c;
            zfull_o <= full_c;
        end
    end

endmodule

// File: rtl/cplx_iq_mult.sv
// Interleaved complex multiplier top. Real and imaginary samples share a
// port on alternate cycles, phase_re_i marking the real one. Results leave
// four cycles after the matching input, rounded/saturated on z_o and exact
// on zfull_o. vld_i is only delayed, never used by the datapath.
// Assumes real and imaginary samples of a number arrive on adjacent cycles.
module cplx_iq_mult
    import cim_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic              phase_re_i,
    input  logic [DW-1:0]     x_i,
    input  logic [DW-1:0]     y_i,
    output logic [DW-1:0]     z_o,
    output logic [2*DW-1:0]   zfull_o,
    output logic              vld_o
);

    localparam int PW = 2 * DW;

    logic [CIM_TAPS-1:0][DW-1:0] x_taps, y_taps;
    phase_e                      phase_q;
    logic [PW-1:0]               prod0, prod1;
    logic                        prod_real;

    // Register the phase flag in step with operand tap 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IMAG;
        end else begin
            phase_q <= phase_e'(phase_re_i);
        end
    end

    cim_tap_line #(.DW(DW), .TAPS(CIM_TAPS)) i_xline (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (x_i),
        .tap_o (x_taps)
    );

    cim_tap_line #(.DW(DW), .TAPS(CIM_TAPS)) i_yline (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (y_i),
        .tap_o (y_taps)
    );

    cim_pair_mult #(.DW(DW), .TAPS(CIM_TAPS)) i_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase_q),
        .xt_i    (x_taps),
        .yt_i    (y_taps),
        .prod0_o (prod0),
        .prod1_o (prod1),
        .real_o  (prod_real)
    );

    cim_combine #(.DW(DW)) i_comb (
        .clk     (clk),
        .rst_n   (rst_n),
        .prod0_i (prod0),
        .prod1_i (prod1),
        .real_i  (prod_real),
        .z_o     (z_o),
        .zfull_o (zfull_o)
    );

    cim_flag_delay #(.LAT(CIM_LATENCY)) i_vld (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (vld_i),
        .flag_o (vld_o)
    );

endmodule

// File: rtl/cim_checker.sv
// Property checker for cplx_iq_mult, attached with bind below.
// Relates the valid delay, reset clearing, and the narrow output to the
// wide output (tracking and saturation at both ends).
module cim_checker #(
    parameter int DW = 18
) (
    input logic            clk,
    input logic            rst_n,
    input logic            vld_i,
    input logic            vld_o,
    input logic [DW-1:0]   z_o,
    input logic [2*DW-1:0] zfull_o
);

    localparam int PW = 2 * DW;
    localparam logic signed [PW-1:0] UNIT   = {2'b01, {(PW-2){1'b0}}};
    localparam logic signed [PW-1:0] HALF_Z = {{(DW+1){1'b0}}, 1'b1, {(DW-2){1'b0}}};
    localparam logic signed [PW-1:0] POS_TH = UNIT - HALF_Z;
    localparam logic signed [PW-1:0] NEG_TH = -UNIT - HALF_Z;
    localparam logic [DW-1:0] Z_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] Z_MIN = {1'b1, {(DW-1){1'b0}}};

    logic [2:0]           run_q;
    logic signed [PW-1:0] zf_s, zf_shr, z_ext, diff;
    logic                 pos_sat, neg_sat;

    // Count clock edges since reset was last sampled low, up to four.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (run_q < 3'd4) begin
            run_q <= run_q + 3'd1;
        end
    end

    // Scale relations between the two outputs.
    always_comb begin
        zf_s    = $signed(zfull_o);
        zf_shr  = zf_s >>> (DW - 1);
        z_ext   = {{DW{z_o[DW-1]}}, z_o};
        diff    = z_ext - zf_shr;
        pos_sat = (zf_s >= POS_TH);
        neg_sat = (zf_s < NEG_TH);
    end

    AST_VLD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q >= 3'd4) |-> (vld_o == $past(vld_i, 4))); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (vld_o == 1'b0 && z_o == '0 && zfull_o == '0)); // R9

    AST_POS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        pos_sat |-> (z_o == Z_MAX)); // R6

    AST_NEG_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        neg_sat |-> (z_o == Z_MIN)); // R6

    AST_Z_TRACKS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!pos_sat && !neg_sat) |-> (diff == '0 || diff == PW'(1))); // R5

endmodule

bind cplx_iq_mult cim_checker #(.DW(DW)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_i   (vld_i),
    .vld_o   (vld_o),
    .z_o     (z_o),
    .zfull_o (zfull_o)
);

// File: tb/test_cplx_iq_mult.sv
// Exhaustive bench at DW = 4: every (a, b, c, d) streamed back to back.
module test_cplx_iq_mult;

    localparam int DW    = 4;
    localparam int PW    = 2 * DW;
    localparam int NUM   = 1 << (4 * DW);
    localparam int STEPS = 2 * NUM;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vld_i = 1'b0;
    logic          phase_re_i = 1'b0;
    logic [DW-1:0] x_i = '0;
    logic [DW-1:0] y_i = '0;
    logic [DW-1:0] z_o;
    logic [PW-1:0] zfull_o;
    logic          vld_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int    exp_z [8];
    int    exp_f [8];
    bit    exp_v [8];
    string tag_z [8];
    string tag_f [8];

    always #2 clk = ~clk;

    cplx_iq_mult #(.DW(DW)) i_cplx_iq_mult (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_i      (vld_i),
        .phase_re_i (phase_re_i),
        .x_i        (x_i),
        .y_i        (y_i),
        .z_o        (z_o),
        .zfull_o    (zfull_o),
        .vld_o      (vld_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sx(input int v);
        return (v >= (1 << (DW - 1))) ? v - (1 << DW) : v;
    endfunction

    initial begin
        // R9: reset dominates while inputs are active.
        vld_i = 1'b1; phase_re_i = 1'b1; x_i = 4'h7; y_i = 4'h7;
        repeat (6) @(negedge clk);
        check("R9 vld_o in reset", int'(vld_o), 0);
        check("R9 z_o in reset", int'(z_o), 0);
        check("R9 zfull_o in reset", int'(zfull_o), 0);
        rst_n = 1'b1;
        for (int k = 0; k < STEPS + 4; k++) begin
            @(negedge clk);
            if (k >= 4) begin
                // R1/R4: slot k-4 appears four cycles after it was driven.
                check(tag_z[(k-4)%8], sx(int'(z_o)), exp_z[(k-4)%8]);
                check(tag_f[(k-4)%8], int'($signed(zfull_o)), exp_f[(k-4)%8]);
                check("R8 vld_o delay", int'(vld_o), int'(exp_v[(k-4)%8]));
            end
            if (k < STEPS) begin
                int idx, slot, a, b, c, d, s, zr;
                bit v;
                idx  = k >> 1;
                slot = k & 1;
                a = sx(idx & 15);
                b = sx((idx >> 4) & 15);
                c = sx((idx >> 8) & 15);
                d = sx((idx >> 12) & 15);
                // R8: irregular valid pattern unrelated to the data.
                v = ((idx * 7 + slot) % 5) < 3;
                s = (slot == 0) ? (a * c - b * d) : (a * d + b * c);
                zr = (s + (1 << (DW - 2))) >>> (DW - 1);
                if (zr > (1 << (DW - 1)) - 1) begin
                    exp_z[k%8] = (1 << (DW - 1)) - 1;
                    tag_z[k%8] = "R6 z_o positive saturation";
                end else if (zr < -(1 << (DW - 1))) begin
                    exp_z[k%8] = -(1 << (DW - 1));
                    tag_z[k%8] = "R6 z_o negative saturation";
                end else begin
                    exp_z[k%8] = zr;
                    tag_z[k%8] = "R5 z_o rounding R1 R4";
                end
                if (s > (1 << (PW - 1)) - 1) begin
                    exp_f[k%8] = (1 << (PW - 1)) - 1;
                    tag_f[k%8] = "R7 zfull_o clip";
                end else begin
                    exp_f[k%8] = s;
                    tag_f[k%8] = (slot == 0) ? "R2 zfull_o real R1 R4"
                                             : "R3 zfull_o imag R1 R4";
                end
                exp_v[k%8] = v;
                vld_i      = v;
                phase_re_i = (slot == 0);
                x_i        = DW'((slot == 0) ? a : b);
                y_i        = DW'((slot == 0) ? c : d);
            end else begin
                vld_i      = 1'b0;
                phase_re_i = ~phase_re_i;
                x_i        = '0;
                y_i        = '0;
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule